// File: doc/BRIEF.md
# Translation Unit Control Register Block

This block is the software-facing control plane of one address translation unit. It sits on a simple single-cycle register bus and holds the base address of the first-level translation table, a command register that moves the unit between its paging and stall states, the address and direction of the most recent page fault, and a small interrupt group with raw, mask, masked and write-one-to-clear views.

Toward the hardware side, the block tells the table walker whether translation is on and whether it is held in a stall. It also gives the translation cache one-cycle pulses that flush the whole cache or drop one line. In return it takes one-cycle fault and bus-error events from the walker, plus two live conditions, walker idle and replay buffer empty, which it shows in the status word.

A force-reset command returns every register to zero. Software learns that the reset has completed by polling the table base register until it reads zero. Writes are taken in the cycle they are presented. A read returns its data one cycle after the request.

Top module: `xlt_ctrl_regs`

## Requirements
- R1: After reset every register reads zero except status. Status reads bit 31 = 1 (stall not active), bit 3 = `walker_idle`, bit 4 = `replay_empty`, and all other bits 0. `paging_on`, `stall_on`, `irq` and `dir_base` are 0.
- R2: The table base register (offset 0x00) keeps only bits 31:12 of a write. Writing 0xCAFEBABE reads back 0xCAFEB000, and the same value drives `dir_base`.
- R3: A write of command code 0 to offset 0x08 sets status bit 0 and `paging_on`. Code 1 clears them and also clears the stall. Either change is visible from the cycle after the write.
- R4: Command code 2 sets the stall (status bit 2, `stall_on`) only if paging is already on. Otherwise the status does not change.
- R5: Command code 3 clears the stall and leaves paging on. Status bit 31 is always the inverse of bit 2.
- R6: A `fault_req` pulse while no fault is active does four things: sets status bit 1, loads `fault_va` into the fault address register (0x0C), records `fault_write` in status bit 5, and sets raw interrupt bit 0 (offset 0x14).
- R7: A fault raised while a fault is already active does not reload the fault address. Command code 5 clears the active fault, and the next fault loads its address again.
- R8: A `buserr_req` pulse sets raw interrupt bit 1.
- R9: The mask register (0x1C, bits 1:0) is read/write. The masked view (0x20) reads raw AND mask. `irq` is high exactly when the masked view is non-zero.
- R10: Writing to the clear register (0x18) clears each raw bit written as 1 and leaves raw bits written as 0 unchanged.
- R11: Command code 4 produces a one-cycle `tlb_flush_all` pulse. A write to 0x10 produces a one-cycle `tlb_inval_line` pulse, with the written word on `tlb_inval_va`.
- R12: Command code 6 clears to zero the table base, paging, stall, active fault, write flag, fault address, raw interrupts, mask and gating bit.
- R13: Bit 0 of offset 0x24 is read/write and drives `clk_gate_en`. Reads of unmapped offsets return 0. Command code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| rd_valid | output | 1 | Marks `rdata` valid |
| fault_req | input | 1 | One-cycle page fault event from the walker |
| fault_va | input | 32 | Virtual address of the faulting access |
| fault_write | input | 1 | Faulting access was a write |
| buserr_req | input | 1 | One-cycle bus read error event |
| walker_idle | input | 1 | Walker has no work in flight |
| replay_empty | input | 1 | Replay buffer holds no entries |
| paging_on | output | 1 | Translation enabled |
| stall_on | output | 1 | Translation held in stall |
| dir_base | output | 32 | First-level table base, low 12 bits zero |
| tlb_flush_all | output | 1 | Flush-whole-cache pulse |
| tlb_inval_line | output | 1 | Drop-one-line pulse |
| tlb_inval_va | output | 32 | Address for the line drop |
| clk_gate_en | output | 1 | Automatic clock gating enable |
| irq | output | 1 | Interrupt request |

## Verification
Each command is issued in two contexts: stall requested with paging off and with paging on, and paging disabled while stalled. This separates the gated stall from a plain set/reset flag. Faults are injected as a first fault, a second fault while the first is still active, and a third fault after the done command. Comparing the recorded addresses separates the capture-once rule from capture-every-time. Interrupts are exercised with both sources set under full, partial and empty masks, and cleared one bit at a time, which separates the AND of the masked view from the per-bit effect of the clear. A force reset issued while everything is set shows that every field returns to zero.

// File: rtl/xlt_ctrl_pkg.sv
`timescale 1ns/1ps
package xlt_ctrl_pkg;
  localparam int OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_DIR   = 8'h00;
  localparam logic [OFS_W-1:0] OFS_STAT  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_CMD   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_FADDR = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_LINE  = 8'h10;
  localparam logic [OFS_W-1:0] OFS_RAW   = 8'h14;
  localparam logic [OFS_W-1:0] OFS_CLR   = 8'h18;
  localparam logic [OFS_W-1:0] OFS_MASK  = 8'h1C;
  localparam logic [OFS_W-1:0] OFS_MSKD  = 8'h20;
  localparam logic [OFS_W-1:0] OFS_GATE  = 8'h24;

  typedef enum logic [2:0] {
    CMD_PG_ON    = 3'd0,
    CMD_PG_OFF   = 3'd1,
    CMD_ST_ON    = 3'd2,
    CMD_ST_OFF   = 3'd3,
    CMD_FLUSH    = 3'd4,
    CMD_FLT_DONE = 3'd5,
    CMD_WIPE     = 3'd6,
    CMD_NOP      = 3'd7
  } cmd_e;

  localparam int ST_PAGING = 0;
  localparam int ST_FAULT  = 1;
  localparam int ST_STALL  = 2;
  localparam int ST_IDLE   = 3;
  localparam int ST_REPLAY = 4;
  localparam int ST_FWRITE = 5;

  localparam int IRQ_PF  = 0;
  localparam int IRQ_BUS = 1;
endpackage

// File: rtl/xlt_mode_ctrl.sv
`timescale 1ns/1ps
module xlt_mode_ctrl
  import xlt_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_clr,
  input  logic              cmd_valid,
  input  cmd_e              cmd_code,
  input  logic              fault_req,
  input  logic [DATA_W-1:0] fault_va,
  input  logic              fault_write,
  output logic              paging_q,
  output logic              stall_q,
  output logic              fault_q,
  output logic              fault_wr_q,
  output logic [DATA_W-1:0] fault_addr_q
);
  logic take_fault;
  assign take_fault = fault_req && !fault_q;

  always_ff @(posedge clk) begin
    if (rst || force_clr) begin
      paging_q     <= 1'b0;
      stall_q      <= 1'b0;
      fault_q      <= 1'b0;
      fault_wr_q   <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      if (take_fault) begin
        fault_q      <= 1'b1;
        fault_wr_q   <= fault_write;
        fault_addr_q <= fault_va;
      end
      if (cmd_valid) begin
        case (cmd_code)
          CMD_PG_ON:  paging_q <= 1'b1;
          CMD_PG_OFF: begin
            paging_q <= 1'b0;
            stall_q  <= 1'b0;
          end
          CMD_ST_ON:  if (paging_q) stall_q <= 1'b1;
          CMD_ST_OFF: stall_q <= 1'b0;
          CMD_FLT_DONE: fault_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R3
  paging_on_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_PG_ON && !force_clr) |=> paging_q);

  // R4
  stall_needs_paging_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_q) |-> $past(paging_q));

  // R7
  fault_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_q && fault_req && !force_clr) |=> $stable(fault_addr_q));

  // R12
  wipe_clears_chk: assert property (@(posedge clk) disable iff (rst)
    force_clr |=> (!paging_q && !stall_q && !fault_q && fault_addr_q == '0));
endmodule

// File: rtl/xlt_irq_regs.sv
`timescale 1ns/1ps
module xlt_irq_regs #(
  parameter int IRQ_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_clr,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  logic [IRQ_W-1:0] clr_bits;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst || force_clr) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | set_vec;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  // R10
  clear_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !force_clr && set_vec == '0) |=> ((raw_q & $past(wdata)) == '0));
endmodule

// File: rtl/xlt_ctrl_regs.sv
`timescale 1ns/1ps
module xlt_ctrl_regs
  import xlt_ctrl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IRQ_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  input  logic              fault_req,
  input  logic [DATA_W-1:0] fault_va,
  input  logic              fault_write,
  input  logic              buserr_req,
  input  logic              walker_idle,
  input  logic              replay_empty,
  output logic              paging_on,
  output logic              stall_on,
  output logic [DATA_W-1:0] dir_base,
  output logic              tlb_flush_all,
  output logic              tlb_inval_line,
  output logic [DATA_W-1:0] tlb_inval_va,
  output logic              clk_gate_en,
  output logic              irq
);
  localparam int BASE_W = DATA_W - PAGE_SHIFT;

  logic              cmd_we, force_clr;
  cmd_e              cmd_code;
  logic              fault_q, fault_wr_q;
  logic [DATA_W-1:0] fault_addr_q;
  logic [BASE_W-1:0] base_q;
  logic              gate_q;
  logic [IRQ_W-1:0]  raw_q, mask_q, masked, set_vec;
  logic [DATA_W-1:0] status, rd_mux;

  assign cmd_we    = wr_en && addr == OFS_CMD;
  assign cmd_code  = cmd_e'(wdata[2:0]);
  assign force_clr = cmd_we && cmd_code == CMD_WIPE;

  xlt_mode_ctrl #(.DATA_W(DATA_W)) mode_i (
    .clk(clk), .rst(rst), .force_clr(force_clr),
    .cmd_valid(cmd_we), .cmd_code(cmd_code),
    .fault_req(fault_req), .fault_va(fault_va), .fault_write(fault_write),
    .paging_q(paging_on), .stall_q(stall_on), .fault_q(fault_q),
    .fault_wr_q(fault_wr_q), .fault_addr_q(fault_addr_q)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_PF]  = fault_req;
    set_vec[IRQ_BUS] = buserr_req;
  end

  xlt_irq_regs #(.IRQ_W(IRQ_W)) irq_i (
    .clk(clk), .rst(rst), .force_clr(force_clr), .set_vec(set_vec),
    .clr_we(wr_en && addr == OFS_CLR), .mask_we(wr_en && addr == OFS_MASK),
    .wdata(wdata[IRQ_W-1:0]), .raw_q(raw_q), .mask_q(mask_q),
    .masked(masked), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst || force_clr) begin
      base_q <= '0;
      gate_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFS_DIR)  base_q <= wdata[DATA_W-1:PAGE_SHIFT];
      if (addr == OFS_GATE) gate_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tlb_flush_all  <= 1'b0;
      tlb_inval_line <= 1'b0;
      tlb_inval_va   <= '0;
    end else begin
      tlb_flush_all  <= cmd_we && cmd_code == CMD_FLUSH;
      tlb_inval_line <= wr_en && addr == OFS_LINE;
      if (wr_en && addr == OFS_LINE) tlb_inval_va <= wdata;
    end
  end

  assign dir_base    = {base_q, {PAGE_SHIFT{1'b0}}};
  assign clk_gate_en = gate_q;

  always_comb begin
    status             = '0;
    status[ST_PAGING]  = paging_on;
    status[ST_FAULT]   = fault_q;
    status[ST_STALL]   = stall_on;
    status[ST_IDLE]    = walker_idle;
    status[ST_REPLAY]  = replay_empty;
    status[ST_FWRITE]  = fault_wr_q;
    status[DATA_W-1]   = !stall_on;
  end

  always_comb begin
    case (addr)
      OFS_DIR:   rd_mux = dir_base;
      OFS_STAT:  rd_mux = status;
      OFS_FADDR: rd_mux = fault_addr_q;
      OFS_RAW:   rd_mux = DATA_W'(raw_q);
      OFS_MASK:  rd_mux = DATA_W'(mask_q);
      OFS_MSKD:  rd_mux = DATA_W'(masked);
      OFS_GATE:  rd_mux = DATA_W'(gate_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R2
  dir_base_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DIR && !force_clr) |=>
      (dir_base[DATA_W-1:PAGE_SHIFT] == $past(wdata[DATA_W-1:PAGE_SHIFT])));
endmodule

// File: tb/xlt_ctrl_regs_tb.sv
`timescale 1ns/1ps
module xlt_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic        fault_req = 1'b0, fault_write = 1'b0, buserr_req = 1'b0;
  logic [31:0] fault_va = '0;
  logic        walker_idle = 1'b1, replay_empty = 1'b1;
  logic        paging_on, stall_on, tlb_flush_all, tlb_inval_line, clk_gate_en, irq;
  logic [31:0] dir_base, tlb_inval_va;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xlt_ctrl_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .fault_req(fault_req), .fault_va(fault_va), .fault_write(fault_write),
    .buserr_req(buserr_req), .walker_idle(walker_idle), .replay_empty(replay_empty),
    .paging_on(paging_on), .stall_on(stall_on), .dir_base(dir_base),
    .tlb_flush_all(tlb_flush_all), .tlb_inval_line(tlb_inval_line),
    .tlb_inval_va(tlb_inval_va), .clk_gate_en(clk_gate_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic inject(input logic [31:0] va, input logic w);
    @(negedge clk); fault_req = 1'b1; fault_va = va; fault_write = w;
    @(negedge clk); fault_req = 1'b0;
  endtask

  // Stimulus table: write entries store data, read entries store the expected word.
  localparam int NV = 21;
  localparam logic        V_WR  [NV] = '{0,0,1,0,1,0,1,0,1,0,1,0,1,0,1,0,0,1,0,1,0};
  localparam logic [7:0]  V_ADR [NV] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h08, 8'h04, 8'h08,
                                         8'h04, 8'h08, 8'h04, 8'h08, 8'h04, 8'h1C, 8'h1C,
                                         8'h24, 8'h24, 8'h30, 8'h08, 8'h04, 8'h08, 8'h04};
  localparam logic [31:0] V_DAT [NV] = '{
    32'h8000_0018, // R1 status after reset
    32'h0000_0000, // R1 base after reset
    32'hCAFE_BABE, 32'hCAFE_B000, // R2
    32'd2, 32'h8000_0018,         // R4 stall refused, paging off
    32'd0, 32'h8000_0019,         // R3 paging on
    32'd2, 32'h0000_001D,         // R4 stall taken
    32'd3, 32'h8000_0019,         // R5 stall off, paging kept
    32'd3, 32'd3,                 // R9 mask read/write
    32'd1, 32'd1,                 // R13 gating bit
    32'd0,                        // R13 unmapped offset
    32'd7, 32'h8000_0019,         // R13 code 7 does nothing
    32'd1, 32'h8000_0018};        // R3 paging off
  localparam int V_REQ [NV] = '{1,1,2,2,4,4,3,3,4,4,5,5,9,9,13,13,13,13,13,3,3};

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 outputs after reset
    check("R1 paging_on", {31'd0, paging_on}, 32'd0);
    check("R1 stall_on", {31'd0, stall_on}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 dir_base", dir_base, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (V_WR[i]) wr(V_ADR[i], V_DAT[i]);
      else begin
        rd(V_ADR[i], v);
        check($sformatf("R%0d table[%0d]", V_REQ[i], i), v, V_DAT[i]);
      end
    end

    // R2 base drives output
    check("R2 dir_base port", dir_base, 32'hCAFE_B000);
    // R1 live status inputs
    walker_idle = 1'b0;
    rd(8'h04, v); check("R1 status idle low", v, 32'h8000_0010);
    walker_idle = 1'b1;

    // R11 cache pulses
    wr(8'h08, 32'd4);
    check("R11 flush pulse", {31'd0, tlb_flush_all}, 32'd1);
    @(negedge clk);
    check("R11 flush one cycle", {31'd0, tlb_flush_all}, 32'd0);
    wr(8'h10, 32'h1234_5ABC);
    check("R11 line pulse", {31'd0, tlb_inval_line}, 32'd1);
    check("R11 line address", tlb_inval_va, 32'h1234_5ABC);
    @(negedge clk);
    check("R11 line one cycle", {31'd0, tlb_inval_line}, 32'd0);

    // R6 first fault
    inject(32'hDEAD_1234, 1'b1);
    rd(8'h04, v); check("R6 status fault+write", v, 32'h8000_003A);
    rd(8'h0C, v); check("R6 fault address", v, 32'hDEAD_1234);
    rd(8'h14, v); check("R6 raw bit0", v, 32'd1);
    check("R9 irq on", {31'd0, irq}, 32'd1);
    rd(8'h20, v); check("R9 masked", v, 32'd1);

    // R7 second fault ignored, done, third fault loads
    inject(32'h1111_0000, 1'b0);
    rd(8'h0C, v); check("R7 address held", v, 32'hDEAD_1234);
    wr(8'h08, 32'd5);
    rd(8'h04, v); check("R7 fault cleared", v, 32'h8000_0038);
    inject(32'h2222_0000, 1'b0);
    rd(8'h0C, v); check("R7 new address", v, 32'h2222_0000);

    // R8 bus error
    @(negedge clk); buserr_req = 1'b1;
    @(negedge clk); buserr_req = 1'b0;
    rd(8'h14, v); check("R8 raw both", v, 32'd3);

    // R9 partial and empty masks
    wr(8'h1C, 32'd2);
    rd(8'h20, v); check("R9 masked partial", v, 32'd2);
    check("R9 irq partial", {31'd0, irq}, 32'd1);
    wr(8'h1C, 32'd0);
    rd(8'h20, v); check("R9 masked empty", v, 32'd0);
    check("R9 irq off", {31'd0, irq}, 32'd0);

    // R10 per-bit clear
    wr(8'h18, 32'd1);
    rd(8'h14, v); check("R10 clear bit0 only", v, 32'd2);
    wr(8'h18, 32'd2);
    rd(8'h14, v); check("R10 clear bit1", v, 32'd0);

    // R12 force reset with everything set
    wr(8'h08, 32'd0);
    wr(8'h08, 32'd2);
    wr(8'h1C, 32'd3);
    wr(8'h24, 32'd1);
    @(negedge clk); buserr_req = 1'b1;
    @(negedge clk); buserr_req = 1'b0;
    check("R12 stall set before wipe", {31'd0, stall_on}, 32'd1);
    wr(8'h08, 32'd6);
    rd(8'h00, v); check("R12 base zero", v, 32'd0);
    rd(8'h04, v); check("R12 status", v, 32'h8000_0018);
    rd(8'h0C, v); check("R12 fault address", v, 32'd0);
    rd(8'h14, v); check("R12 raw", v, 32'd0);
    rd(8'h1C, v); check("R12 mask", v, 32'd0);
    rd(8'h24, v); check("R12 gating", v, 32'd0);
    check("R12 outputs", {28'd0, paging_on, stall_on, clk_gate_en, irq}, 32'd0);
    check("R12 dir_base port", dir_base, 32'd0);

    // R3 disabling paging while stalled also drops the stall
    wr(8'h08, 32'd0);
    wr(8'h08, 32'd2);
    wr(8'h08, 32'd1);
    rd(8'h04, v); check("R3 off clears stall", v, 32'h8000_0018);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule